// File: doc/BRIEF.md
# Asynchronous Bus Read Sequencer

This block is the read side of a bus master on a 16-bit asynchronous external bus. An internal client hands it a byte address and an operand size. The block then runs the bus cycles and returns the result right-aligned, together with a one-cycle done pulse.

The size is a byte, a word or a long word. The external bus carries only the word address; the lowest address bit stays inside the block and picks the byte lane. The block asserts an address strobe and one or both data strobes. It holds them until the slave's acknowledge, which arrives with no relation to the clock, has passed a two-flop synchronizer. It then latches the data bus. A long word is fetched as two word cycles at consecutive word addresses. Between the two cycles the strobes are released, and the second cycle waits until the slave has dropped its acknowledge.

Requests that cannot run are refused with an error pulse and start no bus activity. This covers a word or long word at an odd address, and the reserved size code.

Top module: `bus_read_seq`

## Requirements
- R1: After reset, busy, done, err, the address strobe and both data strobes are low, and rd_data is zero.
- R2: A byte read (size code 0) at an even address asserts only the upper strobe (bus_uds). The result is zero in bits 31:8 and carries data bits 15:8 in bits 7:0.
- R3: A byte read at an odd address asserts only the lower strobe (bus_lds). The result is zero in bits 31:8 and carries data bits 7:0 in bits 7:0.
- R4: A word read (size code 1) asserts both strobes in one cycle. bus_addr equals the byte address shifted right by one. The result is zero in bits 31:16 and carries all 16 data bits in bits 15:0.
- R5: A long-word read (size code 2) runs exactly two word cycles. The first goes to the request's word address and fills bits 31:16. The second goes to that word address plus one and fills bits 15:0.
- R6: Between the two halves of a long-word read, the address and data strobes go low. The second cycle begins exactly three clock edges after the acknowledge is negated, and never while the synchronized acknowledge is still high.
- R7: The acknowledge passes two synchronizer flops. The strobes are released, and the data is latched, on the third rising clock edge after the acknowledge rises. Until then the strobes stay asserted.
- R8: A word or long-word request at an odd address, or a request with size code 3, gives a one-cycle err pulse. No strobe is asserted and busy stays low.
- R9: A request is taken only while the sequencer is idle. Busy is high from acceptance until the cycle in which the one-cycle done pulse appears. Requests made while busy have no effect.
- R10: The bus address is stable for as long as the address strobe stays asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request, sampled while idle |
| req_addr | input | ADDR_W | Byte address of the operand |
| req_size | input | 2 | 0 byte, 1 word, 2 long word, 3 reserved |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse, rd_data valid |
| err | output | 1 | One-cycle pulse, request refused |
| rd_data | output | 32 | Right-aligned read result |
| bus_addr | output | ADDR_W-1 | External word address (byte address bits ADDR_W-1:1) |
| bus_as | output | 1 | Address strobe (active high) |
| bus_uds | output | 1 | Upper byte lane strobe, data bits 15:8 |
| bus_lds | output | 1 | Lower byte lane strobe, data bits 7:0 |
| bus_ack | input | 1 | Asynchronous acknowledge from the slave |
| bus_data | input | 16 | Data bus from the slave |

## Verification
The assertions check several rules on every clock:
- the bus address does not move under an asserted strobe;
- a strobe does not rise while the synchronized acknowledge is still high;
- the strobes are held until the acknowledge is seen;
- a refused request never opens a cycle;
- done marks the end of busy;
- a byte cycle never drives both lanes.

Only the bench scenarios can show the rest: the values returned in each lane and the ordering of long-word halves, with a slave that varies its response delay; the exact three-edge synchronizer latency; and the fact that a request made during a transfer changes nothing.

// File: rtl/brs_pkg.sv
package brs_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CYCLE   = 2'd1,
    ST_RELEASE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/brs_ack_sync.sv
module brs_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= async_in;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/brs_lane_map.sv
module brs_lane_map
  import brs_pkg::*;
(
  input  size_e       sel_size,
  input  logic        sel_a0,
  output logic        stb_upper,
  output logic        stb_lower,
  input  size_e       cap_size,
  input  logic        cap_a0,
  input  logic [15:0] bus_word,
  output logic [15:0] placed
);
  always_comb begin
    if (sel_size == SZ_BYTE) begin
      stb_upper = ~sel_a0;
      stb_lower = sel_a0;
    end else begin
      stb_upper = 1'b1;
      stb_lower = 1'b1;
    end
  end

  always_comb begin
    if (cap_size == SZ_BYTE)
      placed = {8'h00, cap_a0 ? bus_word[7:0] : bus_word[15:8]};
    else
      placed = bus_word;
  end
endmodule

// File: rtl/bus_read_seq.sv
module bus_read_seq
  import brs_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [31:0]       rd_data,
  output logic [ADDR_W-2:0] bus_addr,
  output logic              bus_as,
  output logic              bus_uds,
  output logic              bus_lds,
  input  logic              bus_ack,
  input  logic [15:0]       bus_data
);
  localparam int WA_W = ADDR_W - 1;

  seq_state_e      state_q;
  size_e           size_q;
  size_e           req_sz;
  logic            a0_q;
  logic            half_q;
  logic            ack_s;
  logic            up_sel;
  logic            lo_sel;
  logic [15:0]     placed;
  logic            refuse;
  logic [WA_W-1:0] waddr_q;
  logic [31:0]     rd_q;
  logic            as_q, uds_q, lds_q, busy_q, done_q, err_q;

  assign req_sz = size_e'(req_size);
  assign refuse = (req_sz == SZ_RSVD) || ((req_sz != SZ_BYTE) && req_addr[0]);

  brs_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(bus_ack), .sync_out(ack_s)
  );

  brs_lane_map u_lane (
    .sel_size(req_sz), .sel_a0(req_addr[0]),
    .stb_upper(up_sel), .stb_lower(lo_sel),
    .cap_size(size_q), .cap_a0(a0_q),
    .bus_word(bus_data), .placed(placed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      size_q  <= SZ_BYTE;
      a0_q    <= 1'b0;
      half_q  <= 1'b0;
      waddr_q <= '0;
      rd_q    <= '0;
      as_q    <= 1'b0;
      uds_q   <= 1'b0;
      lds_q   <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (refuse) begin
              err_q <= 1'b1;
            end else begin
              state_q <= ST_CYCLE;
              size_q  <= req_sz;
              a0_q    <= req_addr[0];
              half_q  <= 1'b0;
              waddr_q <= req_addr[ADDR_W-1:1];
              rd_q    <= '0;
              as_q    <= 1'b1;
              uds_q   <= up_sel;
              lds_q   <= lo_sel;
              busy_q  <= 1'b1;
            end
          end
        end
        ST_CYCLE: begin
          if (ack_s) begin
            if (size_q == SZ_LONG && !half_q) rd_q[31:16] <= bus_data;
            else rd_q[15:0] <= placed;
            as_q    <= 1'b0;
            uds_q   <= 1'b0;
            lds_q   <= 1'b0;
            state_q <= ST_RELEASE;
          end
        end
        ST_RELEASE: begin
          if (!ack_s) begin
            if (size_q == SZ_LONG && !half_q) begin
              half_q  <= 1'b1;
              waddr_q <= waddr_q + 1'b1;
              as_q    <= 1'b1;
              uds_q   <= 1'b1;
              lds_q   <= 1'b1;
              state_q <= ST_CYCLE;
            end else begin
              state_q <= ST_IDLE;
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;
  assign rd_data  = rd_q;
  assign bus_addr = waddr_q;
  assign bus_as   = as_q;
  assign bus_uds  = uds_q;
  assign bus_lds  = lds_q;

  assert_byte_single_lane_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_uds && bus_lds) |-> (size_q != SZ_BYTE));
  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (bus_as && $past(bus_as)) |-> $stable(bus_addr));
  assert_restart_after_release_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_as) |-> !ack_s);
  assert_hold_until_ack_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_as && !ack_s) |=> bus_as);
  assert_refuse_no_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    err |-> (!bus_as && !busy && !bus_uds && !bus_lds));
  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));
endmodule

// File: tb/bus_read_seq_bench.sv
module bus_read_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 24;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_size = 2'd0;
  logic              busy, done, err, bus_as, bus_uds, bus_lds;
  logic [31:0]       rd_data;
  logic [ADDR_W-2:0] bus_addr;
  logic              bus_ack = 1'b0;
  logic [15:0]       bus_data = 16'hDEAD;

  int checks = 0;
  int fails = 0;
  int pcount = 0;
  int ncyc = 0;
  int drop_pc = 0;
  logic [ADDR_W-2:0] cyc_addr [4];
  logic              cyc_uds  [4];
  logic              cyc_lds  [4];
  int                cyc_gap  [4];
  int                cyc_lat  [4];

  bus_read_seq #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) u_bus_read_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .busy(busy), .done(done), .err(err),
    .rd_data(rd_data), .bus_addr(bus_addr), .bus_as(bus_as),
    .bus_uds(bus_uds), .bus_lds(bus_lds), .bus_ack(bus_ack),
    .bus_data(bus_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(posedge clk);
    pcount++;
  end

  function automatic logic [15:0] mem_word(input logic [ADDR_W-2:0] w);
    return {w[7:0] ^ 8'hC6, w[15:8] + w[7:0] + 8'h1B};
  endfunction

  function automatic logic [31:0] expect_val(input logic [ADDR_W-1:0] a, input logic [1:0] sz);
    logic [ADDR_W-2:0] w;
    logic [15:0] m;
    w = a[ADDR_W-1:1];
    m = mem_word(w);
    case (sz)
      2'd0:    return {24'h0, a[0] ? m[7:0] : m[15:8]};
      2'd1:    return {16'h0, m};
      default: return {m, mem_word(w + 1'b1)};
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // slave model: random acknowledge delay, records every bus cycle
  initial begin
    forever begin
      @(negedge clk);
      if (bus_as && !bus_ack) begin
        int idx;
        int n;
        idx = (ncyc < 4) ? ncyc : 3;
        cyc_addr[idx] = bus_addr;
        cyc_uds[idx]  = bus_uds;
        cyc_lds[idx]  = bus_lds;
        cyc_gap[idx]  = pcount - drop_pc;
        ncyc++;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        bus_data = mem_word(bus_addr);
        bus_ack  = 1'b1;
        n = 0;
        while (bus_as) begin
          @(negedge clk);
          n++;
        end
        cyc_lat[idx] = n;
        bus_ack  = 1'b0;
        bus_data = 16'hDEAD;
        drop_pc  = pcount;
      end
    end
  end

  task automatic do_read(input logic [ADDR_W-1:0] a, input logic [1:0] sz, input bit poke);
    bit legal;
    logic [31:0] exp;
    int k;
    legal = !(sz == 2'd3 || (sz != 2'd0 && a[0]));
    @(negedge clk);
    ncyc = 0;
    req_valid = 1'b1;
    req_addr = a;
    req_size = sz;
    @(negedge clk);
    req_valid = 1'b0;
    if (!legal) begin
      chk(err && !busy && !bus_as && !bus_uds && !bus_lds, "R8 refuse pulse",
          {28'h0, err, busy, bus_as, bus_uds | bus_lds}, 32'h8);
      @(negedge clk);
      chk(!err && ncyc == 0, "R8 single pulse, no cycle", {31'h0, err} + ncyc, 32'h0);
      return;
    end
    chk(busy, "R9 busy after accept", {31'h0, busy}, 32'h1);
    if (poke) begin
      req_valid = 1'b1;
      req_addr  = a ^ 24'h000F02;
      req_size  = 2'd0;
    end
    k = 0;
    while (!done && k < 400) begin
      if (!busy) chk(0, "R9 busy held until done", {31'h0, busy}, 32'h1);
      @(negedge clk);
      k++;
    end
    req_valid = 1'b0;
    exp = expect_val(a, sz);
    chk(done, "R9 done seen", {31'h0, done}, 32'h1);
    case (sz)
      2'd0: begin
        chk(rd_data == exp, a[0] ? "R3 byte odd data" : "R2 byte even data", rd_data, exp);
        chk(cyc_uds[0] == !a[0] && cyc_lds[0] == a[0], a[0] ? "R3 lower lane only" : "R2 upper lane only",
            {30'h0, cyc_uds[0], cyc_lds[0]}, {30'h0, !a[0], a[0]});
      end
      2'd1: begin
        chk(rd_data == exp, "R4 word data", rd_data, exp);
        chk(cyc_uds[0] && cyc_lds[0] && cyc_addr[0] == a[ADDR_W-1:1], "R4 strobes and address",
            {7'h0, cyc_addr[0], cyc_uds[0], cyc_lds[0]}, {7'h0, a[ADDR_W-1:1], 2'b11});
      end
      default: begin
        chk(rd_data == exp, "R5 long data", rd_data, exp);
        chk(cyc_addr[0] == a[ADDR_W-1:1] && cyc_addr[1] == a[ADDR_W-1:1] + 1'b1, "R5 half addresses",
            {8'h0, cyc_addr[1]}, {8'h0, a[ADDR_W-1:1] + 1'b1});
        chk(cyc_gap[1] == 3, "R6 gap before second half", cyc_gap[1], 32'd3);
      end
    endcase
    chk(ncyc == ((sz == 2'd2) ? 2 : 1), poke ? "R9 request while busy ignored" : "R5 cycle count",
        ncyc, (sz == 2'd2) ? 32'd2 : 32'd1);
    chk(cyc_lat[0] == 3, "R7 acknowledge latency", cyc_lat[0], 32'd3);
    @(negedge clk);
    chk(!done && !busy, "R9 done single pulse", {30'h0, done, busy}, 32'h0);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !err && !bus_as && !bus_uds && !bus_lds && rd_data == 0, "R1 reset state",
        {26'h0, busy, done, err, bus_as, bus_uds, bus_lds} | rd_data, 32'h0);
    // directed cases
    do_read(24'h001234, 2'd0, 1'b0);
    do_read(24'h001235, 2'd0, 1'b0);
    do_read(24'h00ABCE, 2'd1, 1'b0);
    do_read(24'h00FFFE, 2'd2, 1'b0);
    do_read(24'h000101, 2'd1, 1'b0);
    do_read(24'h000103, 2'd2, 1'b0);
    do_read(24'h000100, 2'd3, 1'b0);
    do_read(24'h003000, 2'd2, 1'b1);
    do_read(24'h003001, 2'd0, 1'b1);
    // constrained random
    for (int i = 0; i < 60; i++) begin
      logic [ADDR_W-1:0] a;
      logic [1:0] s;
      a = ADDR_W'($urandom);
      s = 2'($urandom_range(0, 3));
      if (s != 2'd0 && s != 2'd3 && ($urandom_range(0, 3) != 0)) a[0] = 1'b0;
      do_read(a, s, ($urandom_range(0, 4) == 0));
    end
    finish_run();
  end
endmodule